// File: doc/BRIEF.md
# Serial Frame Transmitter

This block turns parallel bytes into an asynchronous serial line. A frame-format register sets the frame shape: 5 to 8 data bits, an optional parity bit of chosen sense, and a stop period of one, one and a half, or two bit times. Bytes arrive over a ready/valid handshake. The frame is clocked out on a line that rests high, paced by a tick input that pulses sixteen times per bit.

The same register also sets how a received word is trimmed. A separate combinational path clears every bit of an incoming word that lies at or above the programmed word length. When the register's top bit is set, the data path is given over to divisor access and no byte is taken for transmission.

The format is captured when a byte is taken. A register write during a frame therefore changes only later frames.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset the format register holds 0x00, `txd` is 1 and `tx_ready` is 1.
- R2: Format bits [1:0] set the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8. Only that many low bits of `tx_data` are sent.
- R3: A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then high stop time. Each bit spans 16 consumed ticks, and `txd` goes low on the edge that takes the byte.
- R4: Format bit 2 clear gives 16 ticks of stop. Bit 2 set gives 24 ticks with a 5-bit word and 32 ticks with a longer word.
- R5: Format bit 3 set adds a parity bit after the data. Format bit 4 set makes the count of ones in data plus parity even; bit 4 clear makes it odd.
- R6: `tx_ready` falls on the edge that takes a byte and stays low until the edge that consumes the last stop tick, after which it is 1.
- R7: `tx_valid` while `tx_ready` is low has no effect: no extra frame is sent.
- R8: While format bit 7 is 1, `tx_ready` is 0, no byte is taken and `txd` stays high.
- R9: A format write during a frame does not change that frame. It applies from the next byte taken.
- R10: `rx_word_out` equals `rx_word_in` with every bit at index word length or above forced to 0, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcr_we | input | 1 | Write strobe for the format register |
| lcr_wdata | input | 8 | Value written to the format register |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| tx_valid | input | 1 | A byte is offered on tx_data |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial line output, high when idle |
| rx_word_in | input | 8 | Received word before trimming |
| rx_word_out | output | 8 | Received word trimmed to the word length |

## Verification
The properties assume that `baud_tick` is the only thing that moves a frame forward. They also assume that a format write is the only thing, besides a tick, that can raise `tx_ready`. The stimulus therefore generates ticks from a free-running divider. It writes the register only with a strobe one cycle wide, never in the cycle a byte is taken. It offers bytes only after `tx_ready` has been seen high at a falling clock edge, except when it deliberately holds `tx_valid` during a busy frame or while divisor access is selected.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } line_state_e;

    typedef struct packed {
        logic       dlab;
        logic       par_even;
        logic       par_en;
        logic       stop_long;
        logic [1:0] wlen;
    } frame_fmt_t;

endpackage

// File: rtl/sft_ctrl_reg.sv
module sft_ctrl_reg #(
    parameter int REG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    output sft_pkg::frame_fmt_t fmt
);
    logic [REG_W-1:0] reg_d, reg_q;
    logic             unused_bits;

    always_comb begin
        reg_d = reg_q;
        if (we) begin
            reg_d = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    // field decode; bits 6:5 carry no transmit meaning
    always_comb begin
        fmt.wlen      = reg_q[1:0];
        fmt.stop_long = reg_q[2];
        fmt.par_en    = reg_q[3];
        fmt.par_even  = reg_q[4];
        fmt.dlab      = reg_q[REG_W-1];
    end

    assign unused_bits = ^reg_q[REG_W-2:5];

endmodule

// File: rtl/sft_word_mask.sv
module sft_word_mask #(
    parameter int DW = 8
) (
    input  logic [1:0]    wlen,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int MIN_LEN = DW - 3;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign dout[i] = din[i] & (i < (MIN_LEN + int'(wlen)));
    end

endmodule

// File: rtl/sft_serializer.sv
module sft_serializer #(
    parameter int TPB = 16,
    parameter int DW  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                ld_valid,
    input  logic [DW-1:0]       ld_data,
    input  sft_pkg::frame_fmt_t fmt,
    output logic                ld_ready,
    output logic                txd
);
    import sft_pkg::*;

    localparam int CW = $clog2(2 * TPB);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] BIT_LAST = CW'(TPB - 1);
    localparam logic [CW-1:0] STOP_1P5 = CW'(TPB + TPB / 2 - 1);
    localparam logic [CW-1:0] STOP_2   = CW'(2 * TPB - 1);
    localparam logic [IW-1:0] IDX_BASE = IW'(DW - 4);

    typedef struct packed {
        line_state_e   st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [IW-1:0] last_idx;
        logic [DW-1:0] sh;
        logic          par;
        logic          par_en;
        logic [CW-1:0] stop_last;
    } ser_t;

    ser_t          s_d, s_q;
    logic [CW-1:0] limit;

    always_comb begin
        s_d      = s_q;
        ld_ready = (s_q.st == ST_IDLE) && !fmt.dlab;
        limit    = (s_q.st == ST_STOP) ? s_q.stop_last : BIT_LAST;

        if (s_q.st == ST_IDLE) begin
            if (ld_valid && ld_ready) begin
                s_d.st       = ST_START;
                s_d.cnt      = '0;
                s_d.idx      = '0;
                s_d.last_idx = IDX_BASE + IW'(fmt.wlen);
                s_d.sh       = ld_data;
                s_d.par      = (^ld_data) ^ ~fmt.par_even;
                s_d.par_en   = fmt.par_en;
                if (!fmt.stop_long) begin
                    s_d.stop_last = BIT_LAST;
                end else if (fmt.wlen == 2'b00) begin
                    s_d.stop_last = STOP_1P5;
                end else begin
                    s_d.stop_last = STOP_2;
                end
            end
        end else if (tick) begin
            if (s_q.cnt == limit) begin
                s_d.cnt = '0;
                case (s_q.st)
                    ST_START: s_d.st = ST_DATA;
                    ST_DATA: begin
                        if (s_q.idx == s_q.last_idx) begin
                            s_d.st = s_q.par_en ? ST_PARITY : ST_STOP;
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                            s_d.sh  = s_q.sh >> 1;
                        end
                    end
                    ST_PARITY: s_d.st = ST_STOP;
                    default:   s_d.st = ST_IDLE;
                endcase
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (s_q.st)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = s_q.sh[0];
            ST_PARITY: txd = s_q.par;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
    parameter int TICKS_PER_BIT = 16,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcr_we,
    input  logic [7:0]        lcr_wdata,
    input  logic              baud_tick,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              txd,
    input  logic [DATA_W-1:0] rx_word_in,
    output logic [DATA_W-1:0] rx_word_out
);
    sft_pkg::frame_fmt_t fmt;
    logic [DATA_W-1:0]   tx_trim;

    sft_ctrl_reg #(.REG_W(8)) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (lcr_we),
        .wdata(lcr_wdata),
        .fmt  (fmt)
    );

    sft_word_mask #(.DW(DATA_W)) u_tx_trim (
        .wlen(fmt.wlen),
        .din (tx_data),
        .dout(tx_trim)
    );

    sft_word_mask #(.DW(DATA_W)) u_rx_trim (
        .wlen(fmt.wlen),
        .din (rx_word_in),
        .dout(rx_word_out)
    );

    sft_serializer #(.TPB(TICKS_PER_BIT), .DW(DATA_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .ld_valid(tx_valid),
        .ld_data (tx_trim),
        .fmt     (fmt),
        .ld_ready(tx_ready),
        .txd     (txd)
    );

endmodule

// File: rtl/sft_props.sv
module sft_props #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lcr_we,
    input logic          lcr_dlab_bit,
    input logic          baud_tick,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          txd,
    input logic [DW-1:0] rx_word_in,
    input logic [DW-1:0] rx_word_out
);
    p_accept_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !txd);

    p_idle_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && !(tx_valid && tx_ready)) |=> $stable(txd));

    p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    p_ready_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> ($past(baud_tick) || $past(lcr_we)));

    p_dlab_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr_we && lcr_dlab_bit) |=> !tx_ready);

    p_mask_subset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_word_out & ~rx_word_in) == '0));

    p_mask_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_out[DW-4:0] == rx_word_in[DW-4:0]));

endmodule

bind serial_frame_tx sft_props #(.DW(DATA_W)) u_props (
    .clk         (clk),
    .rst_n       (rst_n),
    .lcr_we      (lcr_we),
    .lcr_dlab_bit(lcr_wdata[7]),
    .baud_tick   (baud_tick),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .txd         (txd),
    .rx_word_in  (rx_word_in),
    .rx_word_out (rx_word_out)
);

// File: tb/sim_serial_frame_tx.sv
`timescale 1ns/1ps
module sim_serial_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lcr_we = 1'b0;
    logic [7:0] lcr_wdata = 8'h00;
    logic       baud_tick = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready;
    logic       txd;
    logic [7:0] rx_word_in = 8'h00;
    logic [7:0] rx_word_out;

    serial_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .lcr_we(lcr_we), .lcr_wdata(lcr_wdata),
        .baud_tick(baud_tick), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .txd(txd),
        .rx_word_in(rx_word_in), .rx_word_out(rx_word_out)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int          halves;
        logic [31:0] lev;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;
    bit         busy = 0;
    logic [7:0] lcr_m = 8'h00;

    localparam logic [7:0] FMTS  [8] = '{8'h04, 8'h05, 8'h02, 8'h07, 8'h1B, 8'h0B, 8'h1E, 8'h0C};
    localparam logic [7:0] DATAS [8] = '{8'hEA, 8'h2D, 8'hB3, 8'h81, 8'h6B, 8'h6B, 8'h4E, 8'hF3};

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // expected line level per half-bit (8 ticks) of one frame
    function automatic exp_t build(input logic [7:0] d, input logic [7:0] f);
        exp_t e;
        int   n;
        int   h;
        logic p;
        e.lev = '1;
        n = 5 + int'(f[1:0]);
        e.lev[0] = 1'b0;
        e.lev[1] = 1'b0;
        h = 2;
        for (int i = 0; i < n; i++) begin
            e.lev[h] = d[i];
            e.lev[h+1] = d[i];
            h += 2;
        end
        if (f[3]) begin
            p = 1'b0;
            for (int i = 0; i < n; i++) p ^= d[i];
            if (!f[4]) p = ~p;
            e.lev[h] = p;
            e.lev[h+1] = p;
            h += 2;
        end
        h += !f[2] ? 2 : ((n == 5) ? 3 : 4);
        e.halves = h;
        return e;
    endfunction

    // tick every fourth cycle
    initial begin
        int c;
        c = 0;
        forever begin
            @(posedge clk);
            #1;
            baud_tick = (c == 3);
            c = (c + 1) % 4;
        end
    end

    // monitor: pops expected frames and compares the line mid half-bit
    initial begin
        int   n;
        exp_t cur;
        bit   end_pend;
        end_pend = 0;
        n = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (end_pend) begin
                    end_pend = 0;
                    chk(tx_ready == !lcr_m[7], "R6", "ready after last stop tick", tx_ready, !lcr_m[7]);
                    chk(txd == 1'b1, "R3", "line idle after frame", txd, 1);
                end
                if (!busy && txd == 1'b0) begin
                    if (sb.size() == 0) begin
                        chk(0, "R7/R8", "unexpected start bit", 0, 1);
                        cur.halves = 24;
                        cur.lev = '1;
                    end else begin
                        cur = sb.pop_front();
                    end
                    busy = 1;
                    n = 0;
                end
                if (busy && baud_tick) begin
                    n++;
                    if (n % 8 == 4) begin
                        int k;
                        k = (n - 1) / 8;
                        chk(txd == cur.lev[k], "R2/R3/R4/R5", $sformatf("frame half %0d", k), txd, cur.lev[k]);
                    end
                    if (n == cur.halves * 8) begin
                        chk(tx_ready == 1'b0, "R6", "ready low through last stop tick", tx_ready, 0);
                        busy = 0;
                        end_pend = 1;
                    end
                end
            end
        end
    end

    task automatic wr_lcr(input logic [7:0] v);
        @(posedge clk);
        #1;
        lcr_we = 1'b1;
        lcr_wdata = v;
        @(posedge clk);
        #1;
        lcr_we = 1'b0;
        lcr_m = v;
    endtask

    task automatic send(input logic [7:0] d);
        do @(negedge clk); while (!tx_ready);
        @(posedge clk);
        #1;
        sb.push_back(build(d, lcr_m));
        tx_valid = 1'b1;
        tx_data = d;
        @(posedge clk);
        #1;
        tx_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0 || busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        bit         low_seen;
        logic [7:0] m;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
        chk(tx_ready == 1'b1, "R1", "tx_ready after reset", tx_ready, 1);
        rx_word_in = 8'hFF;
        #1;
        chk(rx_word_out == 8'h1F, "R1/R10", "reset format trims to 5 bits", rx_word_out, 8'h1F);

        // R2 R3: 5-bit word, upper bits of the byte must not appear
        send(8'hF5);
        drain();

        // R4 R5: stop lengths and parity senses across word lengths
        for (int i = 0; i < 8; i++) begin
            wr_lcr(FMTS[i]);
            send(DATAS[i]);
            drain();
        end

        // R10: receive trimming for every word length
        for (int w = 0; w < 4; w++) begin
            wr_lcr(8'(w));
            m = 8'((9'h1 << (5 + w)) - 1);
            rx_word_in = 8'hA5;
            @(negedge clk);
            chk(rx_word_out == (8'hA5 & m), "R10", $sformatf("trim A5 wl=%0d", w), rx_word_out, 8'hA5 & m);
            rx_word_in = 8'h5A;
            #1;
            chk(rx_word_out == (8'h5A & m), "R10", $sformatf("trim 5A wl=%0d", w), rx_word_out, 8'h5A & m);
        end

        // R7: offer a byte while a frame is running
        wr_lcr(8'h03);
        send(8'h3C);
        repeat (5) @(posedge clk);
        #1;
        tx_valid = 1'b1;
        tx_data = 8'hC3;
        repeat (20) @(posedge clk);
        #1;
        tx_valid = 1'b0;
        drain();
        repeat (200) @(negedge clk);
        chk(txd == 1'b1 && !busy, "R7", "no extra frame after busy offer", txd, 1);

        // R9: format write mid-frame keeps the running frame
        wr_lcr(8'h1B);
        send(8'h96);
        repeat (30) @(posedge clk);
        wr_lcr(8'h00);
        drain();
        send(8'hFF);
        drain();

        // R8: divisor access selected blocks loads
        wr_lcr(8'h83);
        @(negedge clk);
        chk(tx_ready == 1'b0, "R8", "ready with divisor access", tx_ready, 0);
        @(posedge clk);
        #1;
        tx_valid = 1'b1;
        tx_data = 8'h00;
        low_seen = 0;
        repeat (200) begin
            @(negedge clk);
            if (txd == 1'b0) low_seen = 1;
        end
        tx_valid = 1'b0;
        chk(!low_seen, "R8", "line stayed high with divisor access", low_seen, 0);
        wr_lcr(8'h03);
        @(negedge clk);
        chk(tx_ready == 1'b1, "R8", "ready after divisor access cleared", tx_ready, 1);
        repeat (100) @(negedge clk);
        chk(sb.size() == 0 && !busy, "R8", "no frame from blocked offer", busy, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule